// File: doc/BRIEF.md
# Sample Time-Tag Packetizer

This block sits behind the digitizer of one array channel. Every accepted complex baseband sample gets a 48-bit time tag. The tag is the value of a time counter that advances on the sample clock shared by all channels. A sync pulse loads the same value into that counter on every channel, so all channels agree on the time. Samples are grouped into fixed-length packets, and each packet begins with two header words. The header carries the time of the first payload sample, a sequence number and event flags. A downstream processor can therefore line up packets from many channels at any later time, without sharing a processing clock with them.

A host can arm one event, such as an oscillator phase reset, at a target sample time. The event is marked in the header of the packet that holds the sample at that time, together with the index of that sample in the packet. Because the target time is the same on every channel, each channel marks its own matching packet. If the target time is missed, the packet that holds the first later sample carries a late flag instead. Samples that find the buffer full are dropped, and the header of the affected packet says so.

The input stream has no ready signal, because sampling cannot be paused: samples are taken on every cycle that `smp_valid` is high. The output is a valid/ready stream. A word is transferred only on a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged. Back-pressure backs up into the sample buffer, and once that buffer is full, new samples are dropped.

Top module: `ttag_packetizer`

## Requirements
- R1: After reset the time counter is 0 and it increases by one on every clock. On the clock edge where `sync_pulse` is high, the counter loads `sync_time` instead of counting, and a sample accepted in that same cycle still gets the old counter value.
- R2: Each accepted sample is tagged with the counter value of the cycle in which it is accepted. Header word 1 carries, in bits [47:0], the tag of the packet's first payload sample, and bits [63:48] are zero.
- R3: Each packet is header word 0, then header word 1, then 64 payload words. The samples appear in arrival order, with the sample in bits [31:0] and zero in bits [63:32]. `out_last` is high only on the 64th payload word.
- R4: Header word 0 is laid out as follows: bits [63:48] hold the start marker 16'hA5C3, bits [47:40] hold the flags, bits [39:32] hold the event sample index, bits [31:16] are zero and bits [15:0] hold the sequence number. The flag bits are bit 0 for an event hit, bit 1 for a late event and bit 2 for a discontinuity. The index field is 0 when the packet has no event.
- R5: The first packet after reset has sequence number 0. Each following packet has a number one higher, wrapping modulo 65536.
- R6: A pending event whose target equals the tag of an accepted sample sets flag bit 0 in that sample's packet. The index field then holds the sample's position in the packet (0 to 63), and the event is consumed.
- R7: If an accepted sample's tag is greater than the pending target and no sample matched it, flag bit 1 is set in that sample's packet instead. The index field holds that sample's position, and the event is consumed. A new command replaces a pending one, and a sample in the command's own cycle is compared against the previous state.
- R8: A sample that arrives while the sample buffer is full is discarded. Flag bit 2 is then set in the next packet header produced, and packets completed before the drop are unaffected.
- R9: `out_valid` held high with `out_ready` low keeps `out_valid` high and `out_data` unchanged until the transfer.
- R10: During reset and right after it, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_pulse | input | 1 | Load the time counter on this edge |
| sync_time | input | 48 | Value loaded by the sync pulse |
| smp_valid | input | 1 | A sample is present this cycle |
| smp_data | input | 32 | Complex sample, I and Q packed |
| evt_valid | input | 1 | Arm (or replace) the pending event |
| evt_time | input | 48 | Target sample time of the event |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | 64 | Header or payload word |
| out_last | output | 1 | Last payload word of a packet |

## Verification
Event binding is driven from a table that places the target at the first sample, the last sample, mid-packet, in the past, and just past or deep inside the following packet. Each of these shows whether the flag lands in the right one of two consecutive packets with the right index. The same table repeats with samples on alternate cycles. There an odd target has no matching tag and must become a late mark at the next sample, which separates an equality match from a greater-or-equal match. Directed runs load the counter with distinct values before a packet, replace an armed event, stall the consumer while a header is offered, and overfill the buffer so that only the packet formed after the drop carries the discontinuity flag.

// File: rtl/ttag_pkg.sv
`timescale 1ns/1ps
package ttag_pkg;
  localparam int TIME_W = 48;
  localparam int SMP_W  = 32;
  localparam int WORD_W = 64;
  localparam int SEQ_W  = 16;
  localparam logic [15:0] START_MARK = 16'hA5C3;
  localparam int FLG_HIT  = 0;
  localparam int FLG_LATE = 1;
  localparam int FLG_GAP  = 2;

  typedef struct packed {
    logic [TIME_W-1:0] t0;
    logic [7:0]        flags;
    logic [7:0]        offs;
    logic [SEQ_W-1:0]  seq;
  } hdr_t;

  typedef enum logic [1:0] {ST_HDR0, ST_HDR1, ST_PAY} emit_st_t;
endpackage

// File: rtl/ttag_timebase.sv
`timescale 1ns/1ps
module ttag_timebase #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sync_pulse,
  input  logic [W-1:0] sync_time,
  output logic [W-1:0] now
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          now <= '0;
    else if (sync_pulse) now <= sync_time;
    else                 now <= now + W'(1);
  end

  // R1: a sync edge loads the supplied value
  a_r1_sync_load: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |=> now == $past(sync_time));
  // R1: otherwise the counter steps by one
  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_pulse |=> now == $past(now) + W'(1));
endmodule

// File: rtl/ttag_fifo.sv
`timescale 1ns/1ps
module ttag_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp + AW'(1);
      if (pop)  rp <= rp + AW'(1);
      case ({push, pop})
        2'b10:   cnt <= cnt + (AW+1)'(1);
        2'b01:   cnt <= cnt - (AW+1)'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assign dout  = mem[rp];
  assign full  = (cnt == FULL_CNT);
  assign empty = (cnt == '0);

  // R8: the writer never pushes into a full buffer
  a_r8_push_room: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R9: the reader never pops an empty buffer
  a_r9_pop_data: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/ttag_collector.sv
`timescale 1ns/1ps
module ttag_collector
  import ttag_pkg::*;
#(
  parameter int PKT_LEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] now,
  input  logic              smp_valid,
  input  logic [SMP_W-1:0]  smp_data,
  input  logic              evt_valid,
  input  logic [TIME_W-1:0] evt_time,
  input  logic              smp_full,
  output logic              s_push,
  output logic [SMP_W-1:0]  s_din,
  output logic              h_push,
  output hdr_t              h_din
);
  localparam int IW = $clog2(PKT_LEN);
  localparam logic [IW-1:0] LAST_IDX = IW'(PKT_LEN - 1);

  logic [IW-1:0]     idx;
  logic [TIME_W-1:0] t0_q, tgt_q;
  logic              pend_q;
  logic [7:0]        flags_q, offs_q, flags_n, offs_n;
  logic [SEQ_W-1:0]  seq_q;
  logic              accept, drop, hit, late;

  always_comb begin
    accept  = smp_valid && !smp_full;
    drop    = smp_valid && smp_full;
    hit     = pend_q && accept && (now == tgt_q);
    late    = pend_q && accept && (now > tgt_q);
    flags_n = flags_q;
    flags_n[FLG_HIT]  = flags_q[FLG_HIT]  | hit;
    flags_n[FLG_LATE] = flags_q[FLG_LATE] | late;
    offs_n  = (hit || late) ? 8'(idx) : offs_q;
    s_push  = accept;
    s_din   = smp_data;
    h_push  = accept && (idx == LAST_IDX);
    h_din.t0    = (idx == '0) ? now : t0_q;
    h_din.flags = flags_n;
    h_din.offs  = offs_n;
    h_din.seq   = seq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx     <= '0;
      t0_q    <= '0;
      tgt_q   <= '0;
      pend_q  <= 1'b0;
      flags_q <= '0;
      offs_q  <= '0;
      seq_q   <= '0;
    end else begin
      if (drop) flags_q[FLG_GAP] <= 1'b1;
      if (accept) begin
        if (idx == '0) t0_q <= now;
        if (h_push) begin
          idx     <= '0;
          flags_q <= '0;
          offs_q  <= '0;
          seq_q   <= seq_q + SEQ_W'(1);
        end else begin
          idx     <= idx + IW'(1);
          flags_q <= flags_n;
          offs_q  <= offs_n;
        end
      end
      if (evt_valid) begin
        pend_q <= 1'b1;
        tgt_q  <= evt_time;
      end else if (hit || late) begin
        pend_q <= 1'b0;
      end
    end
  end

  // R5: each completed packet advances the sequence number
  a_r5_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    h_push |=> seq_q == $past(seq_q) + SEQ_W'(1));
  // R6: a matched or missed event does not stay armed
  a_r6_evt_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    (hit || late) && !evt_valid |=> !pend_q);
endmodule

// File: rtl/ttag_emitter.sv
`timescale 1ns/1ps
module ttag_emitter
  import ttag_pkg::*;
#(
  parameter int PKT_LEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  hdr_t              h_dout,
  input  logic              h_empty,
  input  logic [SMP_W-1:0]  s_dout,
  input  logic              s_empty,
  input  logic              out_ready,
  output logic              h_pop,
  output logic              s_pop,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              out_last
);
  localparam int IW = $clog2(PKT_LEN);
  localparam logic [IW-1:0] LAST_IDX = IW'(PKT_LEN - 1);

  emit_st_t      st;
  logic [IW-1:0] pcnt;
  logic          xfer;

  always_comb begin
    case (st)
      ST_HDR0: begin
        out_valid = !h_empty;
        out_data  = {START_MARK, h_dout.flags, h_dout.offs,
                     {(WORD_W-32-SEQ_W){1'b0}}, h_dout.seq};
      end
      ST_HDR1: begin
        out_valid = !h_empty;
        out_data  = {{(WORD_W-TIME_W){1'b0}}, h_dout.t0};
      end
      default: begin
        out_valid = !s_empty;
        out_data  = {{(WORD_W-SMP_W){1'b0}}, s_dout};
      end
    endcase
    xfer     = out_valid && out_ready;
    out_last = (st == ST_PAY) && (pcnt == LAST_IDX);
    h_pop    = xfer && (st == ST_HDR1);
    s_pop    = xfer && (st == ST_PAY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_HDR0;
      pcnt <= '0;
    end else if (xfer) begin
      case (st)
        ST_HDR0: st <= ST_HDR1;
        ST_HDR1: st <= ST_PAY;
        default: begin
          if (pcnt == LAST_IDX) begin
            pcnt <= '0;
            st   <= ST_HDR0;
          end else begin
            pcnt <= pcnt + IW'(1);
          end
        end
      endcase
    end
  end

  // R9: an offered word is held until it is taken
  a_r9_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  // R3: the last payload word is followed by a new header
  a_r3_last_to_hdr: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> st == ST_HDR0);
endmodule

// File: rtl/ttag_packetizer.sv
`timescale 1ns/1ps
module ttag_packetizer
  import ttag_pkg::*;
#(
  parameter int PKT_LEN    = 64,
  parameter int FIFO_DEPTH = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_pulse,
  input  logic [TIME_W-1:0] sync_time,
  input  logic              smp_valid,
  input  logic [SMP_W-1:0]  smp_data,
  input  logic              evt_valid,
  input  logic [TIME_W-1:0] evt_time,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_last
);
  localparam int HDR_DEPTH = FIFO_DEPTH / PKT_LEN;

  logic [TIME_W-1:0] now;
  logic              s_push, s_pop, s_full, s_empty;
  logic [SMP_W-1:0]  s_din, s_dout;
  logic              h_push, h_pop, h_full, h_empty;
  hdr_t              h_din, h_dout;

  ttag_timebase #(.W(TIME_W)) u_time (
    .clk(clk), .rst_n(rst_n), .sync_pulse(sync_pulse),
    .sync_time(sync_time), .now(now));

  ttag_collector #(.PKT_LEN(PKT_LEN)) u_coll (
    .clk(clk), .rst_n(rst_n), .now(now), .smp_valid(smp_valid),
    .smp_data(smp_data), .evt_valid(evt_valid), .evt_time(evt_time),
    .smp_full(s_full), .s_push(s_push), .s_din(s_din),
    .h_push(h_push), .h_din(h_din));

  ttag_fifo #(.W(SMP_W), .DEPTH(FIFO_DEPTH)) u_sbuf (
    .clk(clk), .rst_n(rst_n), .push(s_push), .din(s_din), .pop(s_pop),
    .dout(s_dout), .full(s_full), .empty(s_empty));

  ttag_fifo #(.W($bits(hdr_t)), .DEPTH(HDR_DEPTH)) u_hbuf (
    .clk(clk), .rst_n(rst_n), .push(h_push), .din(h_din), .pop(h_pop),
    .dout(h_dout), .full(h_full), .empty(h_empty));

  ttag_emitter #(.PKT_LEN(PKT_LEN)) u_emit (
    .clk(clk), .rst_n(rst_n), .h_dout(h_dout), .h_empty(h_empty),
    .s_dout(s_dout), .s_empty(s_empty), .out_ready(out_ready),
    .h_pop(h_pop), .s_pop(s_pop), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last));

  // R8: headers in flight never exceed the header buffer
  a_r8_hdr_room: assert property (@(posedge clk) disable iff (!rst_n)
    h_full |-> !h_push);
  // R10: no word is offered in the first cycle out of reset
  a_r10_idle_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);
endmodule

// File: tb/tb_ttag_packetizer.sv
`timescale 1ns/1ps
module tb_ttag_packetizer;
  logic        clk = 1'b0;
  logic        rst_n, sync_pulse, smp_valid, evt_valid, out_ready;
  logic [47:0] sync_time, evt_time;
  logic [31:0] smp_data;
  logic        out_valid, out_last;
  logic [63:0] out_data;

  always #2 clk = ~clk;

  ttag_packetizer #(.PKT_LEN(64), .FIFO_DEPTH(128)) dut (
    .clk(clk), .rst_n(rst_n), .sync_pulse(sync_pulse), .sync_time(sync_time),
    .smp_valid(smp_valid), .smp_data(smp_data), .evt_valid(evt_valid),
    .evt_time(evt_time), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [47:0] mcnt;
  logic [15:0] eseq;
  logic [63:0] cap[$];
  logic        capl[$];
  logic [31:0] expq[$];

  typedef struct packed {
    logic       gap;
    int         delta;
    logic [7:0] f0;
    logic [7:0] o0;
    logic [7:0] f1;
    logic [7:0] o1;
  } row_t;

  localparam row_t ROWS [9] = '{
    '{1'b0,   0, 8'h01, 8'd0,  8'h00, 8'd0},
    '{1'b0,  63, 8'h01, 8'd63, 8'h00, 8'd0},
    '{1'b0,  17, 8'h01, 8'd17, 8'h00, 8'd0},
    '{1'b0,  -5, 8'h02, 8'd0,  8'h00, 8'd0},
    '{1'b0,  64, 8'h00, 8'd0,  8'h01, 8'd0},
    '{1'b0, 100, 8'h00, 8'd0,  8'h01, 8'd36},
    '{1'b1,   3, 8'h02, 8'd2,  8'h00, 8'd0},
    '{1'b1, 126, 8'h01, 8'd63, 8'h00, 8'd0},
    '{1'b1, 129, 8'h00, 8'd0,  8'h02, 8'd1}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic sv, input logic [31:0] sd, input logic ev,
                      input logic [47:0] et, input logic sy, input logic [47:0] st,
                      input logic rdy);
    @(negedge clk);
    smp_valid = sv; smp_data = sd; evt_valid = ev; evt_time = et;
    sync_pulse = sy; sync_time = st; out_ready = rdy;
    #1;
    if (out_valid && out_ready) begin
      cap.push_back(out_data);
      capl.push_back(out_last);
    end
    mcnt = sy ? st : mcnt + 48'd1;
  endtask

  task automatic idle(input int n, input logic rdy);
    for (int k = 0; k < n; k++) tick(1'b0, 32'h0, 1'b0, 48'h0, 1'b0, 48'h0, rdy);
  endtask

  task automatic send(input int n, input logic gap, input logic [31:0] base);
    for (int k = 0; k < n; k++) begin
      tick(1'b1, base + 32'(k), 1'b0, 48'h0, 1'b0, 48'h0, 1'b1);
      expq.push_back(base + 32'(k));
      if (gap) idle(1, 1'b1);
    end
  endtask

  task automatic get_pkt(input string tag, input logic [7:0] f, input logic [7:0] o,
                         input logic [47:0] t0);
    logic [63:0] w;
    logic        l;
    int          bad;
    if (cap.size() < 66) begin
      chk({tag, " R3 packet complete"}, 64'(cap.size()), 64'd66);
      return;
    end
    bad = 0;
    w = cap.pop_front(); l = capl.pop_front();
    if (l !== 1'b0) bad++;
    chk({tag, " R4 R5 header0"}, w, {16'hA5C3, f, o, 16'h0, eseq});
    w = cap.pop_front(); l = capl.pop_front();
    if (l !== 1'b0) bad++;
    chk({tag, " R2 header1"}, w, {16'h0, t0});
    for (int k = 0; k < 64; k++) begin
      logic [31:0] e;
      w = cap.pop_front(); l = capl.pop_front();
      e = (expq.size() > 0) ? expq.pop_front() : 32'hDEAD_BEEF;
      if (w !== {32'h0, e} || l !== (k == 63)) bad++;
    end
    chk({tag, " R3 payload and last"}, 64'(bad), 64'd0);
    eseq = eseq + 16'd1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [47:0] t, tgt;
    rst_n = 1'b0; sync_pulse = 1'b0; sync_time = '0; smp_valid = 1'b0;
    smp_data = '0; evt_valid = 1'b0; evt_time = '0; out_ready = 1'b0;
    mcnt = '0; eseq = '0;
    repeat (4) @(negedge clk);
    #1 chk("R10 valid in reset", 64'(out_valid), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R10 valid after release", 64'(out_valid), 64'd0);
    mcnt = 48'd1;
    idle(3, 1'b1);
    chk("R10 valid idle", 64'(out_valid), 64'd0);

    // R1 R2: counter load before a packet
    tick(1'b0, 0, 1'b0, 0, 1'b1, 48'h1234_5678_9ABC, 1'b1);
    send(64, 1'b0, 32'hA000_0000);
    idle(80, 1'b1);
    get_pkt("R1 sync A", 8'h00, 8'h00, 48'h1234_5678_9ABC);
    tick(1'b0, 0, 1'b0, 0, 1'b1, 48'hFFFF_FFFF_FF00, 1'b1);
    idle(2, 1'b1);
    send(64, 1'b0, 32'hB000_0000);
    idle(80, 1'b1);
    get_pkt("R1 sync B", 8'h00, 8'h00, 48'hFFFF_FFFF_FF02);

    // R6 R7: event binding table
    for (int i = 0; i < 9; i++) begin
      string tag;
      tag = $sformatf("R6/R7 row %0d", i);
      idle(5, 1'b1);
      t = mcnt + 48'd1;
      tgt = (ROWS[i].delta < 0) ? t - 48'(-ROWS[i].delta) : t + 48'(ROWS[i].delta);
      tick(1'b0, 0, 1'b1, tgt, 1'b0, 0, 1'b1);
      send(64, ROWS[i].gap, 32'(i) << 16);
      send(64, ROWS[i].gap, (32'(i) << 16) | 32'h100);
      idle(150, 1'b1);
      get_pkt({tag, " p0"}, ROWS[i].f0, ROWS[i].o0, t);
      get_pkt({tag, " p1"}, ROWS[i].f1, ROWS[i].o1, t + (ROWS[i].gap ? 48'd128 : 48'd64));
    end

    // R7: a second command replaces the first
    idle(5, 1'b1);
    t = mcnt + 48'd2;
    tick(1'b0, 0, 1'b1, t + 48'd10, 1'b0, 0, 1'b1);
    tick(1'b0, 0, 1'b1, t + 48'd20, 1'b0, 0, 1'b1);
    send(64, 1'b0, 32'hC000_0000);
    idle(80, 1'b1);
    get_pkt("R7 replace", 8'h01, 8'd20, t);

    // R9: header held while the consumer stalls
    idle(5, 1'b1);
    t = mcnt;
    send(64, 1'b0, 32'hD000_0000);
    for (int k = 0; k < 4; k++) begin
      tick(1'b0, 0, 1'b0, 0, 1'b0, 0, 1'b0);
      chk("R9 valid held", 64'(out_valid), 64'd1);
      chk("R9 data held", out_data, {16'hA5C3, 8'h00, 8'h00, 16'h0, eseq});
    end
    idle(80, 1'b1);
    get_pkt("R9 after stall", 8'h00, 8'h00, t);

    // R8: overfill with the consumer stalled
    idle(5, 1'b1);
    t = mcnt;
    for (int k = 0; k < 200; k++) begin
      tick(1'b1, 32'(k), 1'b0, 0, 1'b0, 0, 1'b0);
      if (k < 128) expq.push_back(32'(k));
    end
    idle(150, 1'b1);
    get_pkt("R8 before drop a", 8'h00, 8'h00, t);
    get_pkt("R8 before drop b", 8'h00, 8'h00, t + 48'd64);
    t = mcnt;
    send(64, 1'b0, 32'h0000_1000);
    idle(80, 1'b1);
    get_pkt("R8 after drop", 8'h04, 8'h00, t);
    chk("R3 no stray words", 64'(cap.size()), 64'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule